// File: doc/BRIEF.md
# Fractional Clock Enable Generator

This block derives a slow tick from a fast reference clock by counting alone. No clock is synthesised or gated. With default parameters it turns a reference of 13 MHz into an average of 16 kHz. It offers three schemes for getting there:

- a divider that swaps between two adjacent moduli;
- a binary phase accumulator;
- an exact divider that counts events on both the rising and the falling reference edges.

Every scheme drives two outputs. One is a clock-enable pulse, one reference cycle wide, for synchronous logic downstream. The other is a square wave.

The scheme, and the duty style of the exact square wave, are captured while reset is held and are fixed until the next reset. Both-edge counting uses two flops. One is clocked on the rising edge and one on the falling edge, and the output level is their XOR, so neither edge is ever gated. The timing figures below assume a clock period of T.

Top module: `frac_tick_gen`

## Requirements
- R1: `mode_sel` and `duty_sel` are captured only while `rst` is high. Changing them after reset has no effect on the tick schedule. Mode codes: 0 selects the two-modulus divider, 1 selects the accumulator, and 2 or 3 select the exact both-edge divider.
- R2: While `rst` is high, `tick_en` and `sq_out` are both low.
- R3: In mode 0, the divisor is 812 for the first period and then alternates 813, 812, 813 and so on. Tick m (counting from 1) is high in the cycle after clock edge m·812 + floor(m/2) counted from reset release.
- R4: In mode 0, `sq_out` is high for exactly 406 cycles of each period. Its rising edges are 812 or 813 cycles apart.
- R5: In mode 1, a 21-bit accumulator adds 2581 on every cycle. Tick m follows edge ceil(m·2^21/2581), the cycle of the m-th carry. `sq_out` is the accumulator MSB, and its rising edges are 812 or 813 cycles apart.
- R6: In modes 2 and 3, the ticks follow the same alternating 812/813 schedule as R3. This gives exactly one tick per 1625 half-periods.
- R7: In modes 2 and 3 with `duty_sel`=0, `sq_out` rises every 1625·T/2 exactly, with no jitter. It stays high for 812 half-periods.
- R8: In modes 2 and 3 with `duty_sel`=1, `sq_out` is the MSB of the 11-bit event counter. It is high for 601 half-periods and rises every 1625·T/2 exactly.
- R9: `tick_en` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; both edges are used in the exact scheme |
| rst | input | 1 | Synchronous active-high reset; captures the mode and duty selects |
| mode_sel | input | 2 | Scheme select, sampled only during reset |
| duty_sel | input | 1 | Exact-scheme square duty style, sampled only during reset |
| tick_en | output | 1 | One-cycle clock-enable pulse |
| sq_out | output | 1 | Square-wave output |

## Verification
The assertions take for granted three things about the inputs:

- `rst` is held for at least one rising edge, so that the mode capture happens.
- `clk` is free-running, so the rising-edge and falling-edge flops alternate strictly.
- Mode and duty selects may change at any time, because the block ignores them outside reset.

The stimulus always holds reset for several cycles and releases it just after a falling edge. It moves the selects only during reset, except once in mode 0, where it deliberately changes `mode_sel` after release. Square-wave timing is measured in absolute time between output edges, because the exact scheme places edges on falling clock edges.

// File: rtl/frac_pkg.sv
package frac_pkg;
  typedef enum logic [1:0] {
    SCH_TWOMOD = 2'd0,
    SCH_ACCUM  = 2'd1,
    SCH_EXACT  = 2'd2,
    SCH_EXACT2 = 2'd3
  } scheme_e;
endpackage

// File: rtl/twomod_div.sv
module twomod_div #(
  parameter int LO = 812
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o,
  output logic sq_o
);
  localparam int CW   = $clog2(LO + 1);
  localparam int HALF = LO / 2;

  logic [CW-1:0] cnt, c_nxt, last;
  logic          alt;

  assign last  = alt ? CW'(LO) : CW'(LO - 1);
  assign c_nxt = (cnt == last) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      alt    <= 1'b0;
      tick_o <= 1'b0;
      sq_o   <= 1'b0;
    end else begin
      cnt    <= c_nxt;
      tick_o <= (cnt == last);
      sq_o   <= (c_nxt < CW'(HALF));
      if (cnt == last) alt <= ~alt;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(LO));
  // R3
  tm_tick_chk: assert property (@(posedge clk) disable iff (rst) tick_o |-> (cnt == '0));
endmodule

// File: rtl/accum_div.sv
module accum_div #(
  parameter int W   = 21,
  parameter int INC = 2581
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o,
  output logic sq_o
);
  logic [W-1:0] acc;
  logic [W:0]   sum;

  assign sum  = {1'b0, acc} + (W+1)'(INC);
  assign sq_o = acc[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      tick_o <= 1'b0;
    end else begin
      acc    <= sum[W-1:0];
      tick_o <= sum[W];
    end
  end

  // R5
  acc_tick_chk: assert property (@(posedge clk) disable iff (rst) tick_o |-> (acc < W'(INC)));
endmodule

// File: rtl/bothedge_div.sv
module bothedge_div #(
  parameter int DIV = 1625,
  parameter int HI  = 812
) (
  input  logic clk,
  input  logic rst,
  input  logic style_i,
  output logic tick_o,
  output logic sq_o
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt, c_nxt, c_p1;
  logic [CW:0]   c_two;
  logic          r_par, f_par;

  function automatic logic lvl(input logic [CW-1:0] c, input logic sty);
    return sty ? c[CW-1] : (c < CW'(HI));
  endfunction

  assign c_two = {1'b0, cnt} + (CW+1)'(2);
  assign c_nxt = (c_two >= (CW+1)'(DIV)) ? CW'(c_two - (CW+1)'(DIV)) : c_two[CW-1:0];
  assign c_p1  = (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
  assign sq_o  = r_par ^ f_par;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      r_par  <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      cnt    <= c_nxt;
      r_par  <= lvl(c_nxt, style_i) ^ f_par;
      tick_o <= (c_nxt == '0) || (c_nxt == CW'(DIV - 1));
    end
  end

  always_ff @(negedge clk) begin
    if (rst) f_par <= 1'b0;
    else     f_par <= lvl(c_p1, style_i) ^ r_par;
  end

  // R6
  ev_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt < CW'(DIV));
  // R6
  ev_tick_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> ((cnt == '0) || (cnt == CW'(DIV - 1))));
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen #(
  parameter int LO_DIV  = 812,
  parameter int ACC_W   = 21,
  parameter int ACC_INC = 2581,
  parameter int EV_DIV  = 1625,
  parameter int EV_HI   = 812
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       duty_sel,
  output logic       tick_en,
  output logic       sq_out
);
  import frac_pkg::*;

  scheme_e mode_q;
  logic    duty_q;
  logic    tm_tick, tm_sq, ac_tick, ac_sq, ev_tick, ev_sq;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= scheme_e'(mode_sel);
      duty_q <= duty_sel;
    end
  end

  twomod_div #(.LO(LO_DIV)) u_tm (
    .clk(clk), .rst(rst), .tick_o(tm_tick), .sq_o(tm_sq));

  accum_div #(.W(ACC_W), .INC(ACC_INC)) u_ac (
    .clk(clk), .rst(rst), .tick_o(ac_tick), .sq_o(ac_sq));

  bothedge_div #(.DIV(EV_DIV), .HI(EV_HI)) u_ev (
    .clk(clk), .rst(rst), .style_i(duty_q), .tick_o(ev_tick), .sq_o(ev_sq));

  always_comb begin
    case (mode_q)
      SCH_TWOMOD: begin tick_en = tm_tick; sq_out = tm_sq; end
      SCH_ACCUM:  begin tick_en = ac_tick; sq_out = ac_sq; end
      default:    begin tick_en = ev_tick; sq_out = ev_sq; end
    endcase
  end

  // R9
  tick_single_chk: assert property (@(posedge clk) disable iff (rst) tick_en |=> !tick_en);
  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(rst) |=> ($stable(mode_q) && $stable(duty_q)));
endmodule

// File: tb/tb_frac_tick_gen.sv
`timescale 1ns/1ps
module tb_frac_tick_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic       duty_sel = 1'b0;
  logic       tick_en, sq_out;
  int         checks = 0;
  int         fails  = 0;

  localparam real TCK = 20.0;

  frac_tick_gen dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .duty_sel(duty_sel),
    .tick_en(tick_en), .sq_out(sq_out));

  always #10 clk = ~clk;

  initial begin
    #(3600000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input real act, input real exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0.1f expected=%0.1f", req, act, exp_v);
    end
  endtask

  function automatic longint exp_tick(input longint m, input bit acc);
    if (acc) return (m * 64'd2097152 + 64'd2580) / 64'd2581;
    return m * 812 + m / 2;
  endfunction

  task automatic do_reset(input logic [1:0] md, input logic dt);
    @(negedge clk);
    rst = 1'b1; mode_sel = md; duty_sel = dt;
    repeat (4) @(negedge clk);
    // R2: outputs low during reset
    chk(tick_en == 1'b0, "R2 tick in reset", real'(tick_en), 0.0);
    chk(sq_out == 1'b0, "R2 sq in reset", real'(sq_out), 0.0);
    rst = 1'b0;
  endtask

  task automatic run_ticks(input int n, input bit acc, input string req, input bit flip);
    longint lim = exp_tick(n, acc) + 2;
    int m = 1;
    int bad = 0;
    for (longint i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (flip && i == 5) mode_sel = 2'd1;
      if (tick_en) begin
        if (m > n || i != exp_tick(m, acc)) begin
          bad++;
          if (bad < 4) chk(1'b0, req, real'(i), real'(exp_tick(m, acc)));
        end
        m++;
      end
    end
    chk(bad == 0, req, real'(bad), 0.0);
    chk(m == n + 1, req, real'(m - 1), real'(n));
  endtask

  task automatic measure_sq(input int n, input real hi_exp, input real p_a, input real p_b,
                            input string req);
    realtime t0, th, t1;
    @(posedge sq_out);
    @(posedge sq_out);
    t0 = $realtime;
    for (int k = 0; k < n; k++) begin
      @(negedge sq_out); th = $realtime;
      @(posedge sq_out); t1 = $realtime;
      if (hi_exp > 0.0) chk(th - t0 == hi_exp, req, th - t0, hi_exp);
      chk((t1 - t0 == p_a) || (t1 - t0 == p_b), req, t1 - t0, p_a);
      t0 = t1;
    end
  endtask

  task automatic test_twomod();
    do_reset(2'd0, 1'b0);
    // R3 and R1: schedule stays two-modulus after mode_sel changes to 1
    run_ticks(40, 1'b0, "R3/R1 two-modulus tick time", 1'b1);
    // R4
    measure_sq(4, 406.0 * TCK, 812.0 * TCK, 813.0 * TCK, "R4 two-modulus square");
  endtask

  task automatic test_accum();
    do_reset(2'd1, 1'b0);
    // R5
    run_ticks(40, 1'b1, "R5 accumulator tick time", 1'b0);
    measure_sq(4, -1.0, 812.0 * TCK, 813.0 * TCK, "R5 accumulator square");
  endtask

  task automatic test_exact_even();
    do_reset(2'd2, 1'b0);
    // R6
    run_ticks(24, 1'b0, "R6 exact tick time", 1'b0);
    // R7
    measure_sq(8, 812.0 * TCK / 2.0, 1625.0 * TCK / 2.0, 1625.0 * TCK / 2.0, "R7 exact square");
  endtask

  task automatic test_exact_msb();
    do_reset(2'd3, 1'b1);
    // R8
    measure_sq(8, 601.0 * TCK / 2.0, 1625.0 * TCK / 2.0, 1625.0 * TCK / 2.0, "R8 exact msb square");
  endtask

  initial begin
    test_twomod();
    test_accum();
    test_exact_even();
    test_exact_msb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule